// File: doc/BRIEF.md
# Timing-Based Anneal Sequencer

This block drives the two global enables of a coupled-oscillator spin array for one solve. On a start request it first turns the oscillators on. It then turns the coupling latches on so the spins can settle. After that it repeatedly drops coupling for a short gap, which frees the spins to reshuffle, and turns it back on so they can settle again. Once the programmed number of gaps has run, a final settle period follows. A single-cycle sample strobe then marks the moment the spin states may be captured, while coupling is still on.

All three timing values are captured when the start request is accepted: the settle length, the gap length and the number of gaps. Later changes on those inputs do not affect a solve already running. A value of zero counts as one. A one-cycle done pulse closes the solve, with both enables low, and the block then waits for the next start.

Top module: `anneal_sequencer`

## Requirements
- R1: While reset is high, and in the cycle after it falls, all four outputs (oscillator enable, coupling enable, sample, done) are low.
- R2: A start accepted in idle gives exactly one cycle with the oscillator enable high and the coupling enable low, before any coupling.
- R3: After that cycle, N rounds follow. Each round is S cycles with both enables high, then A cycles with the oscillator enable high and the coupling enable low. S is the settle length, A the gap length and N the gap count.
- R4: A value of zero for S, A or N behaves exactly like a value of one.
- R5: After the last round, S more cycles run with both enables high. The sample strobe is then high for exactly one cycle, with both enables still high.
- R6: The cycle after the sample strobe has done high for exactly one cycle with both enables low. The block is then idle with all outputs low and accepts a new start.
- R7: A start that arrives while a solve is running, including during its sample and done cycles, has no effect on the output trace.
- R8: S, A and N are captured in the cycle the start is accepted; later changes on those inputs do not alter the running solve.
- R9: The coupling enable is never high while the oscillator enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only when idle |
| settle_len_i | input | 16 | Settle length S in cycles (0 acts as 1) |
| gap_len_i | input | 16 | Coupling-off gap length A in cycles (0 acts as 1) |
| pulse_num_i | input | 16 | Number of gaps N per solve (0 acts as 1) |
| osc_en_o | output | 1 | Global oscillator enable |
| couple_en_o | output | 1 | Global coupling-latch enable |
| sample_o | output | 1 | One-cycle capture strobe |
| done_o | output | 1 | One-cycle end-of-solve pulse |

## Verification
Two functions can fall in the same cycle:
- A new start request can coincide with the end of a solve, in the sample or done cycle.
- A change of the timing inputs can coincide with an accepted start, or come just after it.

The bench provokes both by pulsing start exactly in the sample cycle and in the done cycle, and by rewriting S, A and N a few cycles into a solve. It judges each case by comparing the full per-cycle output trace against one computed from the values captured at the accepted start. The trace must end in a clean idle, with no second solve launched.

// File: rtl/anneal_pkg.sv
package anneal_pkg;

    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OSC,
        ST_COUPLE,
        ST_GAP,
        ST_FINAL,
        ST_SAMPLE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        cnt_t settle;
        cnt_t gap;
        cnt_t rounds;
    } solve_cfg_t;

    typedef struct packed {
        logic osc_en;
        logic cpl_en;
        logic sample;
        logic done;
    } drive_t;

    function automatic cnt_t at_least_one(cnt_t v);
        return (v == '0) ? cnt_t'(1) : v;
    endfunction

    function automatic drive_t decode_drive(seq_state_e st);
        drive_t d;
        d = '0;
        unique case (st)
            ST_OSC:    d.osc_en = 1'b1;
            ST_COUPLE: begin d.osc_en = 1'b1; d.cpl_en = 1'b1; end
            ST_GAP:    d.osc_en = 1'b1;
            ST_FINAL:  begin d.osc_en = 1'b1; d.cpl_en = 1'b1; end
            ST_SAMPLE: begin d.osc_en = 1'b1; d.cpl_en = 1'b1; d.sample = 1'b1; end
            ST_DONE:   d.done = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int W = anneal_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            // a period of L cycles ends when the count reaches zero; L of 0 acts as 1
            remain_q <= (load_val == '0) ? '0 : load_val - W'(1);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - W'(1);
        end
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/pulse_tally.sv
module pulse_tally #(
    parameter int W = anneal_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic         last
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= W'(1);
        end else if (load) begin
            left_q <= (load_val == '0) ? W'(1) : load_val;
        end else if (step && left_q > W'(1)) begin
            left_q <= left_q - W'(1);
        end
    end

    assign last = (left_q == W'(1));
endmodule

// File: rtl/anneal_sequencer.sv
module anneal_sequencer
    import anneal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] settle_len_i,
    input  logic [CNT_W-1:0] gap_len_i,
    input  logic [CNT_W-1:0] pulse_num_i,
    output logic             osc_en_o,
    output logic             couple_en_o,
    output logic             sample_o,
    output logic             done_o
);
    seq_state_e state_q, state_d;
    solve_cfg_t cfg_q;
    drive_t     drv;

    logic       tmr_load;
    cnt_t       tmr_val;
    logic       tmr_expired;
    logic       tally_load;
    logic       tally_step;
    logic       tally_last;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pulse_tally #(.W(CNT_W)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .load     (tally_load),
        .load_val (pulse_num_i),
        .step     (tally_step),
        .last     (tally_last)
    );

    always_comb begin
        state_d    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = cfg_q.settle;
        tally_load = 1'b0;
        tally_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d    = ST_OSC;
                    tally_load = 1'b1;
                end
            end
            ST_OSC: begin
                state_d  = ST_COUPLE;
                tmr_load = 1'b1;
                tmr_val  = cfg_q.settle;
            end
            ST_COUPLE: begin
                if (tmr_expired) begin
                    state_d  = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_q.gap;
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    tally_step = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = cfg_q.settle;
                    state_d    = tally_last ? ST_FINAL : ST_COUPLE;
                end
            end
            ST_FINAL: begin
                if (tmr_expired) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cfg_q.settle <= at_least_one(settle_len_i);
                cfg_q.gap    <= at_least_one(gap_len_i);
                cfg_q.rounds <= at_least_one(pulse_num_i);
            end
        end
    end

    always_comb drv = decode_drive(state_q);

    assign osc_en_o    = drv.osc_en;
    assign couple_en_o = drv.cpl_en;
    assign sample_o    = drv.sample;
    assign done_o      = drv.done;
endmodule

// File: rtl/anneal_seq_checker.sv
module anneal_seq_checker (
    input logic clk,
    input logic rst,
    input logic osc_en_o,
    input logic couple_en_o,
    input logic sample_o,
    input logic done_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> !osc_en_o && !couple_en_o && !sample_o && !done_o);

    assert_osc_before_couple_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en_o) |-> !couple_en_o);

    assert_sample_coupled_R5: assert property (@(posedge clk) disable iff (rst)
        sample_o |-> osc_en_o && couple_en_o);

    assert_sample_single_R5: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> !sample_o);

    assert_done_after_sample_R6: assert property (@(posedge clk) disable iff (rst)
        sample_o |=> done_o);

    assert_done_released_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !osc_en_o && !couple_en_o && !sample_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !osc_en_o);

    assert_no_abort_R7: assert property (@(posedge clk) disable iff (rst)
        (osc_en_o && !sample_o) |=> osc_en_o);

    assert_couple_needs_osc_R9: assert property (@(posedge clk) disable iff (rst)
        couple_en_o |-> osc_en_o);
endmodule

bind anneal_sequencer anneal_seq_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .osc_en_o    (osc_en_o),
    .couple_en_o (couple_en_o),
    .sample_o    (sample_o),
    .done_o      (done_o)
);

// File: tb/test_anneal_sequencer.sv
`timescale 1ns/1ps
module test_anneal_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] settle = '0;
    logic [15:0] gap = '0;
    logic [15:0] pnum = '0;
    logic        osc_en, cpl_en, smp, dn;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    anneal_sequencer i_anneal_sequencer (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .settle_len_i (settle),
        .gap_len_i    (gap),
        .pulse_num_i  (pnum),
        .osc_en_o     (osc_en),
        .couple_en_o  (cpl_en),
        .sample_o     (smp),
        .done_o       (dn)
    );

    function automatic logic [3:0] outs();
        return {osc_en, cpl_en, smp, dn};
    endfunction

    // expected {osc, couple, sample, done} at index t after the accepted start
    function automatic logic [3:0] expv(int t, int s, int a, int n);
        int ss = (s == 0) ? 1 : s;
        int aa = (a == 0) ? 1 : a;
        int nn = (n == 0) ? 1 : n;
        int u;
        if (t == 0) return 4'b1000;
        u = t - 1;
        if (u < nn * (ss + aa)) return ((u % (ss + aa)) < ss) ? 4'b1100 : 4'b1000;
        u = u - nn * (ss + aa);
        if (u < ss)      return 4'b1100;
        if (u == ss)     return 4'b1110;
        if (u == ss + 1) return 4'b0001;
        return 4'b0000;
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag, input int t);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: got %b expected %b", tag, t, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // one solve; start re-pulsed at index inj, inputs rewritten at index chg (-1 = never)
    task automatic run_solve(input int s, input int a, input int n,
                             input int inj, input int chg, input string tag);
        int ss = (s == 0) ? 1 : s;
        int aa = (a == 0) ? 1 : a;
        int nn = (n == 0) ? 1 : n;
        int len = 1 + nn * (ss + aa) + ss + 2;
        @(negedge clk);
        settle = 16'(s); gap = 16'(a); pnum = 16'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t < len + 3; t++) begin
            if (t > 0) @(negedge clk);
            check(outs(), expv(t, s, a, n), tag, t);
            start = (t == inj);
            if (t == chg) begin
                settle = 16'd9; gap = 16'd7; pnum = 16'd5;
            end
        end
        start = 1'b0;
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(outs(), 4'b0000, "R1 during reset", 0);
        rst = 1'b0;
        @(negedge clk);
        check(outs(), 4'b0000, "R1 after reset", 1);
        @(negedge clk);
        check(outs(), 4'b0000, "R1 idle", 2);
    endtask

    task automatic test_basic();
        run_solve(3, 2, 3, -1, -1, "R2/R3/R5/R6/R9 basic 3-2-3");
        run_solve(1, 5, 1, -1, -1, "R3/R5 single gap");
        run_solve(4, 1, 2, -1, -1, "R3 short gap");
    endtask

    task automatic test_zero();
        run_solve(0, 0, 0, -1, -1, "R4 all zero");
        run_solve(0, 3, 2, -1, -1, "R4 zero settle");
        run_solve(2, 0, 0, -1, -1, "R4 zero gap and count");
    endtask

    task automatic test_ignore_start();
        // S=2 A=1 N=2: len = 1+6+2+2 = 11, sample at 9, done at 10
        run_solve(2, 1, 2, 3, -1, "R7 start mid-run");
        run_solve(2, 1, 2, 9, -1, "R7 start in sample cycle");
        run_solve(2, 1, 2, 10, -1, "R7 start in done cycle");
    endtask

    task automatic test_latched();
        run_solve(3, 2, 2, -1, 0, "R8 inputs changed at index 0");
        run_solve(2, 3, 3, -1, 4, "R8 inputs changed mid-run");
    endtask

    task automatic test_back_to_back();
        run_solve(1, 1, 1, -1, -1, "R6 first solve");
        run_solve(2, 2, 1, -1, -1, "R6 restart from idle");
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        test_reset();
        test_basic();
        test_zero();
        test_ignore_start();
        test_latched();
        test_back_to_back();
        summary();
        $finish;
    end

endmodule